// File: doc/BRIEF.md
# Interrupt Mapping and Request Controller

This block gathers 64 level-sensitive interrupt lines and turns them into a single outstanding request. The request appears as one asserted bit on a 64-bit vector, together with a numeric request code. Lines 0 to 31 come from bus slots. Lines 32 to 63 come from on-board devices. Software reaches the block through a small register port, where it enables lines through mapping registers and retires requests through clear registers.

Each slot mapping register serves a group of four slot lines. Each on-board line has its own mapping register. When no request is outstanding, the block takes the lowest-numbered line that is high and enabled, and holds it until software clears it. A request ends when software clears the matching group or line, or when it disables the mapping of the requested line. Selection then runs again at once.

Top module: `intmap_ctrl`

## Requirements
- R1: After reset, `req_code` is 65 (idle), `req_vec` is zero, and every mapping register reads with bit 31 clear. Slot group g reads 0x7C0 | (4·g). On-board line n reads 0x7E0 + n.
- R2: Register addresses are 10 bits wide, and a register is decoded only when address bit 2 is set. Slot map g is at 0x000 + 8·g + 4 (g 0..7). On-board map n is at 0x100 + 8·n + 4 (n 0..31). Slot clear g is at 0x200 + 8·g + 4. On-board clear n is at 0x300 + 8·n + 4. Reads return the mapping value at a map address and zero everywhere else.
- R3: A write to a mapping register changes only bit 31, which is the enable bit. Bits 30:0 always read their initial value.
- R4: When the block selects, it picks the lowest-numbered line whose input is high and whose mapping is enabled. Slot line i uses group i/4, and on-board line 32+n uses map n. All slot lines therefore come before all on-board lines.
- R5: While a request is outstanding, `req_code` and `req_vec` stay unchanged until the request is dropped, even when other enabled lines rise. `req_vec` has at most one bit set.
- R6: Lowering the input of the requested line does not withdraw the request.
- R7: Writing 0 to bit 31 of the mapping register that covers the requested line drops the request, and selection runs in the same cycle. Disabling any other mapping leaves the request unchanged.
- R8: A write to slot clear g drops the request when the request is a slot line with line/4 = g, and selection runs again. Otherwise the write has no effect.
- R9: A write to on-board clear n drops the request only when the request is line 32+n, and selection runs again.
- R10: A write with address bit 2 clear, or to an address outside the listed registers, has no effect.
- R11: When the block is idle and an enabled line is high at a clock edge, the request for that line appears right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 64 | Interrupt levels: slot lines 0..31, on-board lines 32..63 |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 10 | Register address for reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| req_vec | output | 64 | One-hot request vector, zero when idle |
| req_code | output | 7 | Number of the requested line, 65 when idle |

## Verification
The assertions assume that `irq_in`, `wr_en`, `addr` and `wr_data` are synchronous to `clk` and stable around the rising edge. The hold and start properties also assume that a cycle with no write is a cycle with no register effect. The bench therefore changes every input only on the falling edge and raises the write strobe for exactly one cycle per access. Random traffic mixes sparse line patterns with writes to every register region. That traffic includes lower-word and out-of-range addresses, so the ignored-write cases are exercised as well.

// File: rtl/intmap_ctrl.sv
module intmap_ctrl #(
  parameter int SLOT_LINES = 32,
  parameter int OB_LINES = 32,
  localparam int NLINES = SLOT_LINES + OB_LINES,
  localparam int CODE_W = $clog2(NLINES + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic              wr_en,
  input  logic [9:0]        addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic [NLINES-1:0] req_vec,
  output logic [CODE_W-1:0] req_code
);
  localparam int NGRP = SLOT_LINES / 4;
  localparam logic [CODE_W-1:0] IDLE = CODE_W'(NLINES + 1);
  localparam logic [CODE_W-1:0] C_SLOT = CODE_W'(SLOT_LINES);
  localparam logic [CODE_W-1:0] C_NL = CODE_W'(NLINES);

  logic [NGRP-1:0]     en_grp, en_grp_n;
  logic [OB_LINES-1:0] en_ob, en_ob_n;
  logic [NLINES-1:0]   en_line, en_line_n;
  logic [CODE_W-1:0]   cur, cur_n, sel;

  wire       hi  = addr[2];
  wire [1:0] rgn = addr[9:8];
  wire [4:0] idx = addr[7:3];
  wire [CODE_W-1:0] idx_c = CODE_W'(idx);

  wire wr_gmap = wr_en & hi & (rgn == 2'd0) & (int'(idx) < NGRP);
  wire wr_omap = wr_en & hi & (rgn == 2'd1) & (int'(idx) < OB_LINES);
  wire wr_gclr = wr_en & hi & (rgn == 2'd2) & (int'(idx) < NGRP);
  wire wr_oclr = wr_en & hi & (rgn == 2'd3) & (int'(idx) < OB_LINES);

  wire cur_slot = cur < C_SLOT;
  wire cur_ob   = (cur >= C_SLOT) && (cur < C_NL);
  wire [CODE_W-1:0] cur_grp = cur >> 2;
  wire [CODE_W-1:0] cur_obi = cur - C_SLOT;
  wire hit_grp = cur_slot && (cur_grp == idx_c);
  wire hit_ob  = cur_ob && (cur_obi == idx_c);

  wire drop = (wr_gmap & ~wr_data[31] & hit_grp)
            | (wr_omap & ~wr_data[31] & hit_ob)
            | (wr_gclr & hit_grp)
            | (wr_oclr & hit_ob);

  always_comb begin
    en_grp_n = en_grp;
    for (int g = 0; g < NGRP; g++)
      if (wr_gmap && int'(idx) == g) en_grp_n[g] = wr_data[31];
  end

  always_comb begin
    en_ob_n = en_ob;
    for (int n = 0; n < OB_LINES; n++)
      if (wr_omap && int'(idx) == n) en_ob_n[n] = wr_data[31];
  end

  genvar i;
  generate
    for (i = 0; i < NLINES; i++) begin : g_line
      if (i < SLOT_LINES) begin : g_slot
        assign en_line[i]   = en_grp[i/4];
        assign en_line_n[i] = en_grp_n[i/4];
      end else begin : g_ob
        assign en_line[i]   = en_ob[i-SLOT_LINES];
        assign en_line_n[i] = en_ob_n[i-SLOT_LINES];
      end
      assign req_vec[i] = (cur == CODE_W'(i));
    end
  endgenerate

  wire [NLINES-1:0] cand = irq_in & en_line_n;

  always_comb begin
    sel = IDLE;
    for (int k = NLINES - 1; k >= 0; k--)
      if (cand[k]) sel = CODE_W'(k);
  end

  assign cur_n = (cur == IDLE || drop) ? sel : cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_grp <= '0;
      en_ob  <= '0;
      cur    <= IDLE;
    end else begin
      en_grp <= en_grp_n;
      en_ob  <= en_ob_n;
      cur    <= cur_n;
    end
  end

  always_comb begin
    rd_data = '0;
    if (hi && rgn == 2'd0)
      for (int g = 0; g < NGRP; g++)
        if (int'(idx) == g) rd_data = {en_grp[g], 31'(32'h7C0 | (g << 2))};
    if (hi && rgn == 2'd1)
      for (int n = 0; n < OB_LINES; n++)
        if (int'(idx) == n) rd_data = {en_ob[n], 31'(32'h7E0 + n)};
  end

  assign req_code = cur;

  a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_vec));

  a_r1_idle_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (req_code == IDLE) |-> (req_vec == '0));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_code != IDLE && !wr_en) |=> $stable(req_code));

  a_r11_start: assert property (@(posedge clk) disable iff (!rst_n)
    (req_code == IDLE && !wr_en && |(irq_in & en_line)) |=> (req_code != IDLE));

  a_r4_source: assert property (@(posedge clk) disable iff (!rst_n)
    (req_code != IDLE && req_code != $past(req_code)) |-> |(req_vec & $past(irq_in)));
endmodule

// File: tb/intmap_ctrl_bench.sv
module intmap_ctrl_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] irq_in = '0;
  logic        wr_en = 0;
  logic [9:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [63:0] req_vec;
  logic [6:0]  req_code;

  int tests = 0;
  int fails = 0;

  logic [7:0]  m_grp;
  logic [31:0] m_ob;
  int          m_cur;

  always #10 clk = ~clk;

  intmap_ctrl u_intmap_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .req_vec(req_vec), .req_code(req_code)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [9:0] a);
    int ix = int'(a[7:3]);
    if (!a[2]) return 32'h0;
    if (a[9:8] == 2'd0 && ix < 8) return {m_grp[ix], 31'(32'h7C0 | (ix << 2))};
    if (a[9:8] == 2'd1) return {m_ob[ix], 31'(32'h7E0 + ix)};
    return 32'h0;
  endfunction

  task automatic model_step(input logic [63:0] irq, input logic w,
                            input logic [9:0] a, input logic [31:0] d);
    int  ix = int'(a[7:3]);
    bit  dr = 0;
    bit  slot = (m_cur < 32);
    bit  ob = (m_cur >= 32 && m_cur < 64);
    logic [63:0] en;
    if (w && a[2]) begin
      case (a[9:8])
        2'd0: if (ix < 8) begin
          if (!d[31] && slot && m_cur / 4 == ix) dr = 1;
          m_grp[ix] = d[31];
        end
        2'd1: begin
          if (!d[31] && ob && m_cur - 32 == ix) dr = 1;
          m_ob[ix] = d[31];
        end
        2'd2: if (ix < 8 && slot && m_cur / 4 == ix) dr = 1;
        default: if (ob && m_cur - 32 == ix) dr = 1;
      endcase
    end
    for (int k = 0; k < 32; k++) en[k] = m_grp[k/4];
    for (int k = 0; k < 32; k++) en[32+k] = m_ob[k];
    if (m_cur == 65 || dr) begin
      m_cur = 65;
      for (int k = 63; k >= 0; k--) if (irq[k] & en[k]) m_cur = k;
    end
  endtask

  task automatic cyc(input logic [63:0] irq, input logic w,
                     input logic [9:0] a, input logic [31:0] d);
    irq_in = irq; wr_en = w; addr = a; wr_data = d;
    model_step(irq, w, a, d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic chk_req(input string tag);
    check(tag, 64'(req_code), 64'(m_cur));
    check(tag, req_vec, (m_cur < 64) ? (64'd1 << m_cur) : 64'd0);
  endtask

  task automatic chk_rd(input string tag, input logic [9:0] a);
    addr = a;
    #1;
    check(tag, 64'(rd_data), 64'(exp_rd(a)));
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] irq;
    void'($urandom(32'h5EED1234));
    m_grp = '0; m_ob = '0; m_cur = 65;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_req("R1 reset idle");
    chk_rd("R1 slot map 3 init", 10'h01C);
    check("R1 slot map 3 value", 64'(rd_data), 64'h7CC);
    chk_rd("R1 onboard map 5 init", 10'h12C);
    check("R1 onboard map 5 value", 64'(rd_data), 64'h7E5);
    chk_rd("R2 lower word reads zero", 10'h018);
    chk_rd("R2 clear reg reads zero", 10'h204);

    cyc('0, 1, 10'h004, 32'hFFFFFFFF);
    chk_rd("R3 only bit31 written", 10'h004);
    check("R3 value", 64'(rd_data), 64'h800007C0);
    cyc('0, 1, 10'h008, 32'h80000000);
    chk_rd("R10 lower-word write ignored", 10'h00C);
    check("R10 value", 64'(rd_data), 64'h7C4);
    cyc('0, 1, 10'h0CC, 32'h80000000);
    chk_req("R10 out-of-range write");

    cyc(64'h2, 0, 10'h0, 0);
    chk_req("R11 start from idle");
    check("R11 code", 64'(req_code), 64'd1);
    cyc(64'h2, 1, 10'h00C, 32'h80000000);
    cyc(64'h26, 0, 10'h0, 0);
    chk_req("R5 hold while others rise");
    check("R5 code", 64'(req_code), 64'd1);
    cyc(64'h24, 0, 10'h0, 0);
    chk_req("R6 input low keeps request");
    cyc(64'h24, 1, 10'h20C, 0);
    chk_req("R8 clear other group no effect");
    check("R8 code held", 64'(req_code), 64'd1);
    cyc(64'h24, 1, 10'h204, 0);
    chk_req("R8 clear group 0 reselects");
    check("R4 lowest picked", 64'(req_code), 64'd2);
    cyc(64'h24, 1, 10'h00C, 0);
    chk_req("R7 disable other group no effect");
    check("R7 code held", 64'(req_code), 64'd2);
    cyc(64'h24, 1, 10'h004, 0);
    chk_req("R7 disable active group withdraws");
    check("R7 idle", 64'(req_code), 64'd65);

    cyc(64'h0, 1, 10'h11C, 32'h80000000);
    cyc(64'h0, 1, 10'h13C, 32'h80000000);
    cyc(64'h88_0000_0000, 0, 10'h0, 0);
    check("R4 onboard lowest", 64'(req_code), 64'd35);
    cyc(64'h88_0000_0000, 1, 10'h33C, 0);
    chk_req("R9 clear other line no effect");
    cyc(64'h88_0000_0000, 1, 10'h31C, 0);
    check("R9 clear with level high reselects same", 64'(req_code), 64'd35);
    cyc(64'h80_0000_0000, 1, 10'h03C, 32'h80000000);
    cyc(64'h80_4000_0000, 0, 10'h0, 0);
    check("R5 slot rise held behind onboard", 64'(req_code), 64'd35);
    cyc(64'h80_4000_0000, 1, 10'h31C, 0);
    chk_req("R4 slot before onboard");
    check("R4 code 30", 64'(req_code), 64'd30);

    for (int t = 0; t < 600; t++) begin
      logic        w;
      logic [9:0]  a;
      logic [31:0] d;
      irq = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      w = ($urandom % 4) == 0;
      a = 10'($urandom);
      if ($urandom % 3 != 0) a[2] = 1;
      d = $urandom;
      cyc(irq, w, a, d);
      chk_req("R4 R5 R7 R8 R9 random");
      chk_rd("R2 R3 random read", 10'($urandom) | 10'h004);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule